// File: doc/BRIEF.md
# Per-Port VLAN Action Header Editor

This block sits on the egress side of one output port, directly after that port's packet queue. Each port of a switch carries its own copy. Packets arrive as a stream of 64-bit words with an 8-bit control sideband, a valid/ready handshake and an end-of-packet flag. Words with a non-zero control code are metadata headers that sit in front of the frame. The first word of every packet is the queue header. A separate metadata word, marked by its own control code, may carry a VLAN tag and a flag that says whether the tag is valid.

A single configuration register, loaded through a simple write strobe, selects the action applied to every departing packet. In tag mode, an existing VLAN metadata word gets the configured tag. If the packet has no such word, one is created. In strip mode, an existing VLAN metadata word is kept but marked invalid. In pass mode, packets leave untouched. The bytes of the Ethernet frame itself are never changed.

The block holds the queue header for one cycle while it looks at the word that follows. It therefore knows whether a VLAN word is present before it releases any header. When it must insert a word, it takes one stall cycle on its input.

Top module: `vlan_action_editor`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and the configuration is pass mode with a tag of 0.
- R2: A write with `cfg_wr_en` high loads the configuration. Bits [17:16] select the action: 00 is pass, 01 is tag, 10 is strip, and 11 behaves exactly as pass. Bits [15:0] hold the tag.
- R3: In tag mode, when the second word of a packet does not carry control code 0x20, a new word is emitted directly after the first word. The new word has control 0x20, data bit 16 set to 1, data bits [15:0] equal to the tag, all other data bits 0, and end-of-packet 0. Every original word follows unchanged.
- R4: In pass mode, every word (data, control and end-of-packet) leaves exactly as it arrived.
- R5: In tag mode, when the second word carries control 0x20, its data bits [15:0] are replaced by the tag and bit 16 is set to 1. All other bits and all other words are unchanged.
- R6: In strip mode, when the second word carries control 0x20, its data bit 16 is cleared. All other bits are kept, and the word is not removed.
- R7: In strip mode, a packet whose second word is not a 0x20 word leaves unchanged.
- R8: Only the word directly after the queue header counts as the VLAN word. A 0x20-coded word in any later position is neither edited nor treated as present.
- R9: The action and tag are captured when a packet's first word is accepted. A write during a packet, or in the same cycle as its first word, applies only to later packets.
- R10: No word is lost, duplicated or reordered under output back-pressure. With `out_ready` held high, a packet of N words is accepted over N cycles, or N+1 cycles when a word is inserted.
- R11: A packet of one word leaves unchanged in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 18 | Action in [17:16], tag in [15:0] |
| in_data | input | 64 | Incoming word |
| in_ctrl | input | 8 | Incoming control code (0 for frame data) |
| in_eop | input | 1 | Incoming word is the last of its packet |
| in_valid | input | 1 | Incoming word present |
| in_ready | output | 1 | Block accepts the incoming word |
| out_data | output | 64 | Outgoing word |
| out_ctrl | output | 8 | Outgoing control code |
| out_eop | output | 1 | Outgoing word is the last of its packet |
| out_valid | output | 1 | Outgoing word present |
| out_ready | input | 1 | Downstream accepts the outgoing word |

## Verification
Two functions can fall in the same cycle. First, a configuration write can land in the same cycle as the handshake of a packet's first word. The bench provokes this with a write that coincides with an accepted first word, and it expects that packet to follow the old setting while the next packet follows the new one. Second, the insertion stall can coincide with output back-pressure. The bench throttles `out_ready` with a fixed duty pattern while packets that need an inserted word stream through. A scoreboard then judges the outgoing words in order, so that any lost, doubled or misplaced word is reported.

// File: rtl/vlan_edit_pkg.sv
package vlan_edit_pkg;

    typedef enum logic [1:0] {
        ACT_PASS  = 2'b00,
        ACT_TAG   = 2'b01,
        ACT_STRIP = 2'b10,
        ACT_RSVD  = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        PH_FIRST,
        PH_SECOND,
        PH_INSERT,
        PH_BODY
    } phase_e;

endpackage

// File: rtl/vlan_cfg_reg.sv
module vlan_cfg_reg
    import vlan_edit_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W+1:0] wr_data,
    output act_e             act,
    output logic [TAG_W-1:0] tag
);

    typedef struct packed {
        act_e             act;
        logic [TAG_W-1:0] tag;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [1:0] sel;

    assign sel = wr_data[TAG_W+1:TAG_W];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.tag = wr_data[TAG_W-1:0];
            // the reserved code folds onto pass
            cfg_d.act = (sel == 2'b11) ? ACT_PASS : act_e'(sel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{act: ACT_PASS, tag: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign act = cfg_q.act;
    assign tag = cfg_q.tag;

    assert_tag_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'b01) |=> (act == ACT_TAG && tag == $past(wr_data[TAG_W-1:0])));

    assert_rsvd_folds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'b11) |=> (act == ACT_PASS));

endmodule

// File: rtl/vlan_word_edit.sv
module vlan_word_edit
    import vlan_edit_pkg::*;
#(
    parameter int                DATA_W    = 64,
    parameter int                CTRL_W    = 8,
    parameter int                TAG_W     = 16,
    parameter logic [CTRL_W-1:0] VLAN_CODE = 8'h20
) (
    input  logic [DATA_W-1:0] word_data,
    input  logic [CTRL_W-1:0] word_ctrl,
    input  act_e              act,
    input  logic [TAG_W-1:0]  tag,
    output logic              is_vlan,
    output logic [DATA_W-1:0] edit_data,
    output logic [DATA_W-1:0] fresh_data
);

    localparam int FLAG_BIT = TAG_W;

    assign is_vlan = (word_ctrl == VLAN_CODE);

    always_comb begin
        edit_data = word_data;
        if (is_vlan) begin
            unique case (act)
                ACT_TAG: begin
                    edit_data[TAG_W-1:0] = tag;
                    edit_data[FLAG_BIT]  = 1'b1;
                end
                ACT_STRIP: edit_data[FLAG_BIT] = 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        fresh_data               = '0;
        fresh_data[TAG_W-1:0]    = tag;
        fresh_data[FLAG_BIT]     = 1'b1;
    end

endmodule

// File: rtl/vlan_stream_ctl.sv
module vlan_stream_ctl
    import vlan_edit_pkg::*;
#(
    parameter int                DATA_W    = 64,
    parameter int                CTRL_W    = 8,
    parameter int                TAG_W     = 16,
    parameter logic [CTRL_W-1:0] VLAN_CODE = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              cfg_act,
    input  logic [TAG_W-1:0]  cfg_tag,
    output act_e              pkt_act,
    output logic [TAG_W-1:0]  pkt_tag,
    input  logic              is_vlan,
    input  logic [DATA_W-1:0] edit_data,
    input  logic [DATA_W-1:0] fresh_data,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CTRL_W-1:0] in_ctrl,
    input  logic              in_eop,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [CTRL_W-1:0] out_ctrl,
    output logic              out_eop,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam int FLAG_BIT = TAG_W;

    typedef struct packed {
        phase_e            phase;
        logic              hv;
        logic [DATA_W-1:0] hd;
        logic [CTRL_W-1:0] hc;
        logic              he;
        act_e              act;
        logic [TAG_W-1:0]  tag;
    } ctl_t;

    ctl_t s_d, s_q;
    logic out_fire, in_fire, insert_now;

    always_comb begin
        s_d = s_q;
        // queue header is released only once the following word is visible
        out_valid  = s_q.hv && ((s_q.phase != PH_SECOND) || in_valid);
        out_fire   = out_valid && out_ready;
        insert_now = (s_q.phase == PH_SECOND) && in_valid &&
                     (s_q.act == ACT_TAG) && !is_vlan;
        if (s_q.phase == PH_SECOND) begin
            in_ready = out_ready && !insert_now;
        end else begin
            in_ready = !s_q.hv || out_ready;
        end
        in_fire = in_valid && in_ready;

        if (out_fire) begin
            s_d.hv = 1'b0;
        end

        if (insert_now && out_ready) begin
            s_d.hv    = 1'b1;
            s_d.hd    = fresh_data;
            s_d.hc    = VLAN_CODE;
            s_d.he    = 1'b0;
            s_d.phase = PH_INSERT;
        end else if (in_fire) begin
            s_d.hv = 1'b1;
            s_d.hc = in_ctrl;
            s_d.he = in_eop;
            s_d.hd = (s_q.phase == PH_SECOND) ? edit_data : in_data;
            unique case (s_q.phase)
                PH_FIRST: begin
                    s_d.act   = cfg_act;
                    s_d.tag   = cfg_tag;
                    s_d.phase = in_eop ? PH_FIRST : PH_SECOND;
                end
                default: s_d.phase = in_eop ? PH_FIRST : PH_BODY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_FIRST, hv: 1'b0, hd: '0, hc: '0, he: 1'b0,
                     act: ACT_PASS, tag: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign out_data = s_q.hd;
    assign out_ctrl = s_q.hc;
    assign out_eop  = s_q.he;
    assign pkt_act  = s_q.act;
    assign pkt_tag  = s_q.tag;

    assert_hold_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_ctrl) && $stable(out_eop)));

    assert_insert_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (insert_now && out_ready) |=>
            (out_valid && out_ctrl == VLAN_CODE && out_data[FLAG_BIT] && !out_eop));

    assert_pass_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_SECOND && in_fire && s_q.act == ACT_PASS) |=>
            (out_data == $past(in_data) && out_ctrl == $past(in_ctrl)));

    assert_strip_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_SECOND && in_fire && s_q.act == ACT_STRIP && in_ctrl == VLAN_CODE) |=>
            (!out_data[FLAG_BIT] && out_ctrl == VLAN_CODE));

    assert_act_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_BODY) |=> ($stable(s_q.act) && $stable(s_q.tag)));

endmodule

// File: rtl/vlan_action_editor.sv
module vlan_action_editor
    import vlan_edit_pkg::*;
#(
    parameter int                DATA_W    = 64,
    parameter int                CTRL_W    = 8,
    parameter int                TAG_W     = 16,
    parameter logic [CTRL_W-1:0] VLAN_CODE = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [TAG_W+1:0]  cfg_wr_data,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CTRL_W-1:0] in_ctrl,
    input  logic              in_eop,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [CTRL_W-1:0] out_ctrl,
    output logic              out_eop,
    output logic              out_valid,
    input  logic              out_ready
);

    act_e              cfg_act, pkt_act;
    logic [TAG_W-1:0]  cfg_tag, pkt_tag;
    logic              is_vlan;
    logic [DATA_W-1:0] edit_data, fresh_data;

    vlan_cfg_reg #(.TAG_W(TAG_W)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .act     (cfg_act),
        .tag     (cfg_tag)
    );

    vlan_word_edit #(
        .DATA_W(DATA_W), .CTRL_W(CTRL_W), .TAG_W(TAG_W), .VLAN_CODE(VLAN_CODE)
    ) i_edit (
        .word_data  (in_data),
        .word_ctrl  (in_ctrl),
        .act        (pkt_act),
        .tag        (pkt_tag),
        .is_vlan    (is_vlan),
        .edit_data  (edit_data),
        .fresh_data (fresh_data)
    );

    vlan_stream_ctl #(
        .DATA_W(DATA_W), .CTRL_W(CTRL_W), .TAG_W(TAG_W), .VLAN_CODE(VLAN_CODE)
    ) i_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_act    (cfg_act),
        .cfg_tag    (cfg_tag),
        .pkt_act    (pkt_act),
        .pkt_tag    (pkt_tag),
        .is_vlan    (is_vlan),
        .edit_data  (edit_data),
        .fresh_data (fresh_data),
        .in_data    (in_data),
        .in_ctrl    (in_ctrl),
        .in_eop     (in_eop),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .out_data   (out_data),
        .out_ctrl   (out_ctrl),
        .out_eop    (out_eop),
        .out_valid  (out_valid),
        .out_ready  (out_ready)
    );

endmodule

// File: tb/test_vlan_action_editor.sv
module test_vlan_action_editor;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [17:0] cfg_wr_data = '0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic        in_eop = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] out_data;
    logic [7:0]  out_ctrl;
    logic        out_eop;
    logic        out_valid;
    logic        out_ready = 1'b1;

    int          n_tests = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          throttle = 1'b0;
    bit          finished = 1'b0;
    logic [17:0] model_cfg = '0;

    logic [72:0] exp_q[$];
    string       req_q[$];

    logic [63:0] pd[8];
    logic [7:0]  pc[8];

    vlan_action_editor i_vlan_action_editor (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .in_data(in_data), .in_ctrl(in_ctrl), .in_eop(in_eop), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_ctrl(out_ctrl), .out_eop(out_eop),
        .out_valid(out_valid), .out_ready(out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // output throttle pattern
    initial begin
        forever begin
            @(posedge clk);
            #1;
            out_ready = throttle ? ((cyc % 3) != 0) : 1'b1;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R10: unexpected word got %h expected none",
                         {out_eop, out_ctrl, out_data});
            end else begin
                logic [72:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if ({out_eop, out_ctrl, out_data} !== e) begin
                    n_fail++;
                    $display("FAIL %s: word got %h expected %h", r,
                             {out_eop, out_ctrl, out_data}, e);
                end
            end
        end
    end

    task automatic check(input string r, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", r, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [17:0] v);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v;
        @(posedge clk);
        #1;
        cfg_wr_en = 1'b0;
        model_cfg = v;
    endtask

    // expected stream computed from the requirements, then the packet is driven
    task automatic send_pkt(input int n, input int wr_idx, input logic [17:0] wr_val,
                            input string r, output int span);
        logic [1:0]  m;
        logic [15:0] t;
        logic [63:0] d;
        int          first_acc;
        m = (model_cfg[17:16] == 2'b11) ? 2'b00 : model_cfg[17:16];
        t = model_cfg[15:0];
        exp_q.push_back({(n == 1), pc[0], pd[0]});
        req_q.push_back((n == 1) ? "R11" : r);
        if (n > 1) begin
            d = pd[1];
            if (pc[1] == 8'h20) begin
                if (m == 2'b01) begin d[15:0] = t; d[16] = 1'b1; end
                if (m == 2'b10) d[16] = 1'b0;
            end else if (m == 2'b01) begin
                exp_q.push_back({1'b0, 8'h20, 47'b0, 1'b1, t});
                req_q.push_back("R3");
            end
            exp_q.push_back({(n == 2), pc[1], d});
            req_q.push_back(r);
            for (int i = 2; i < n; i++) begin
                exp_q.push_back({(i == n - 1), pc[i], pd[i]});
                req_q.push_back("R8");
            end
        end
        if (wr_idx >= 0) model_cfg = wr_val;
        first_acc = 0;
        span = 0;
        for (int i = 0; i < n; i++) begin
            bit acc;
            in_data  = pd[i];
            in_ctrl  = pc[i];
            in_eop   = (i == n - 1);
            in_valid = 1'b1;
            if (i == wr_idx) begin
                cfg_wr_en   = 1'b1;
                cfg_wr_data = wr_val;
            end
            acc = 1'b0;
            while (!acc) begin
                @(negedge clk);
                acc = in_ready;
                if (acc && i == 0) first_acc = cyc;
                if (acc && i == n - 1) span = cyc - first_acc;
                @(posedge clk);
                #1;
                cfg_wr_en = 1'b0;
            end
        end
        in_valid = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic load(input logic [7:0] c1, input logic [63:0] d1);
        pd[0] = 64'h0000_0011_2233_4455; pc[0] = 8'hFF;
        pd[1] = d1;                      pc[1] = c1;
        pd[2] = 64'hDEAD_BEEF_0000_0001; pc[2] = 8'h00;
        pd[3] = 64'hCAFE_F00D_0000_0002; pc[3] = 8'h00;
    endtask

    initial begin
        int sp;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {63'b0, out_valid}, 64'd0);
        check("R1", {63'b0, in_ready}, 64'd1);
        @(posedge clk);
        #1;

        // reset configuration is pass; VLAN word untouched
        load(8'h20, 64'hABCD_0000_0000_5123);
        send_pkt(4, -1, '0, "R4", sp);
        check("R10", sp, 3);

        // reserved code behaves as pass
        cfg_write({2'b11, 16'h0777});
        load(8'h00, 64'h1111_2222_3333_4444);
        send_pkt(4, -1, '0, "R2", sp);

        // tag mode, no VLAN word: insertion and one stall cycle
        cfg_write({2'b01, 16'h0ABC});
        load(8'h00, 64'h1111_2222_3333_4444);
        send_pkt(4, -1, '0, "R3", sp);
        check("R10", sp, 4);

        // tag mode, existing VLAN word: rewrite, upper bits kept
        load(8'h20, 64'h5A5A_0000_0000_0123);
        send_pkt(4, -1, '0, "R5", sp);
        check("R10", sp, 3);

        // VLAN code only in a later position: insert, later word untouched
        pd[0] = 64'h77; pc[0] = 8'hFF;
        pd[1] = 64'h99; pc[1] = 8'h40;
        pd[2] = 64'h0001_4321; pc[2] = 8'h20;
        pd[3] = 64'h5; pc[3] = 8'h00;
        send_pkt(4, -1, '0, "R8", sp);

        // single-word packet in tag mode
        pd[0] = 64'h1234; pc[0] = 8'hFF;
        send_pkt(1, -1, '0, "R11", sp);

        // strip mode with and without VLAN word
        cfg_write({2'b10, 16'h0000});
        load(8'h20, 64'h0F00_0000_0001_F00F);
        send_pkt(4, -1, '0, "R6", sp);
        load(8'h00, 64'h0000_0000_0001_F00F);
        send_pkt(3, -1, '0, "R7", sp);

        // mid-packet write: current packet keeps strip, next uses tag
        load(8'h20, 64'h0000_0000_0001_0042);
        send_pkt(4, 2, {2'b01, 16'h0333}, "R9", sp);
        load(8'h20, 64'h0000_0000_0000_0042);
        send_pkt(4, -1, '0, "R9", sp);

        // write in the same cycle as an accepted first word
        load(8'h00, 64'h0000_0000_0000_0099);
        send_pkt(4, 0, {2'b00, 16'h0000}, "R9", sp);
        check("R10", sp, 4);
        load(8'h00, 64'h0000_0000_0000_0099);
        send_pkt(4, -1, '0, "R9", sp);

        // back-pressure with insertion
        cfg_write({2'b01, 16'h0FED});
        throttle = 1'b1;
        for (int k = 0; k < 6; k++) begin
            load((k % 2 == 0) ? 8'h00 : 8'h20, 64'h100 + k);
            send_pkt(2 + (k % 3), -1, '0, "R10", sp);
        end
        throttle = 1'b0;
        repeat (20) @(posedge clk);
        #1;
        check("R10", exp_q.size(), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R10: watchdog expired got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule